// File: doc/BRIEF.md
# Gated Up/Down Edge Counter

This block counts events arriving on two independent asynchronous digital lines. Each rising edge on the increment line adds one to a signed register, and each rising edge on the decrement line subtracts one. A third asynchronous line acts as a level-sensitive inhibit. While that line is high, edges on either counting line are discarded.

All three lines are brought into the clock domain through two-stage synchronisers. Rising edges are found by comparing the synchronised sample with the one from the cycle before. The inhibit line goes through the same number of stages, so it stays aligned with the edges it masks.

Alongside the count, a flag output is driven directly from the register. The flag is high whenever the current value is divisible by four. It can serve as a periodic marker for an external sequencer.

Top module: `gated_updown_counter`

## Requirements
- R1: A rising edge on `up_i` alone, with the inhibit low, raises `count_o` by exactly one.
- R2: A rising edge on `dn_i` alone, with the inhibit low, lowers `count_o` by exactly one.
- R3: While the synchronised `gate_i` is high, edges on `up_i` and `dn_i` leave `count_o` unchanged. `gate_i` passes through the same two-stage synchroniser as the counting lines.
- R4: `mult4_o` is 1 exactly when bits [1:0] of `count_o` are both 0, decoded without a register. After reset the count is 0 and `mult4_o` is 1.
- R5: Without a detected edge, `count_o` holds its value. A counting line held high for many cycles produces a single step.
- R6: Rising edges on `up_i` and `dn_i` detected in the same cycle leave `count_o` unchanged.
- R7: `count_o` is a WIDTH-bit two's-complement value, 16 by default. It wraps modulo 2^WIDTH: max+1 gives min, and 0-1 gives all ones.
- R8: Each input is synchronised by two flip-flops, and an edge is a previous synchronised sample of 0 followed by a current one of 1. Suppose an input rises before clock edge k with the inhibit low. `count_o` then keeps its old value after edge k+1 and shows the new value after edge k+2.
- R9: `rst_ni` low clears the count and all synchroniser and edge state, asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Asynchronous increment line, rising-edge sensitive |
| dn_i | input | 1 | Asynchronous decrement line, rising-edge sensitive |
| gate_i | input | 1 | Asynchronous inhibit, high freezes the count |
| count_o | output | WIDTH | Signed count value |
| mult4_o | output | 1 | High when count_o is divisible by four |

## Verification
A wrong step size or a wrong direction shows on `count_o` after the third clock edge following the stimulus. The error then persists, because the register never re-derives its value. A missing edge register or a missing synchroniser stage changes that latency, or turns a held line into repeated steps. Either fault shows within a few cycles. A narrow-width instance is swept across its full range so that wrap faults show, and `mult4_o` is compared against the modelled count after every step.

// File: rtl/gudc_pkg.sv
package gudc_pkg;
  localparam int unsigned NUM_CH = 3;
  typedef enum int unsigned {
    CH_UP   = 0,
    CH_DN   = 1,
    CH_GATE = 2
  } ch_e;
endpackage

// File: rtl/gudc_sync_bank.sv
module gudc_sync_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign level_o[g] = sync_q;
    assign rise_o[g]  = sync_q & ~prev_q;

    // a detected edge cannot repeat on the next cycle
    p_single_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/gudc_count_core.sv
module gudc_count_core #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             hold_i,
  output logic [WIDTH-1:0] count_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (!hold_i) begin
      unique case ({inc_i, dec_i})
        2'b10:   count_d = count_q + ONE;
        2'b01:   count_d = count_q - ONE;
        default: count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end

  assign count_o = count_q;

  p_inc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && !hold_i) |=> count_q == $past(count_q) + ONE);
  p_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && !hold_i) |=> count_q == $past(count_q) - ONE);
  p_gate_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(count_q));
  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !dec_i) |=> $stable(count_q));
  p_cancel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i) |=> $stable(count_q));
endmodule

// File: rtl/gated_updown_counter.sv
module gated_updown_counter
  import gudc_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             gate_i,
  output logic [WIDTH-1:0] count_o,
  output logic             mult4_o
);
  logic [NUM_CH-1:0] raw, level, rise;

  assign raw[CH_UP]   = up_i;
  assign raw[CH_DN]   = dn_i;
  assign raw[CH_GATE] = gate_i;

  gudc_sync_bank #(.N(NUM_CH)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (raw),
    .level_o (level),
    .rise_o  (rise)
  );

  gudc_count_core #(.WIDTH(WIDTH)) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (rise[CH_UP]),
    .dec_i   (rise[CH_DN]),
    .hold_i  (level[CH_GATE]),
    .count_o (count_o)
  );

  assign mult4_o = (count_o[1:0] == 2'b00);

  // flag only moves when the count moves
  p_flag_tracks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(count_o) |-> $stable(mult4_o));
endmodule

// File: tb/test_gated_updown_counter.sv
`timescale 1ns/1ps
module test_gated_updown_counter;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic up = 1'b0, dn = 1'b0, gate = 1'b0;
  logic [15:0] cnt16;
  logic [3:0]  cnt4;
  logic        f16, f4;
  int checks = 0, failures = 0;
  logic [15:0] e16 = '0;
  logic [3:0]  e4  = '0;

  always #2.5 clk = ~clk;

  gated_updown_counter i_gated_updown_counter (
    .clk_i(clk), .rst_ni(rst_ni), .up_i(up), .dn_i(dn), .gate_i(gate),
    .count_o(cnt16), .mult4_o(f16));

  gated_updown_counter #(.WIDTH(4)) i_gated_updown_counter_w4 (
    .clk_i(clk), .rst_ni(rst_ni), .up_i(up), .dn_i(dn), .gate_i(gate),
    .count_o(cnt4), .mult4_o(f4));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ncyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    chk(cnt16 == e16, req, int'(cnt16), int'(e16));
    chk(cnt4 == e4, {req, "/w4"}, int'(cnt4), int'(e4));
    chk(f16 == (e16[1:0] == 2'b00), {req, "/R4 flag"}, int'(f16), int'(e16[1:0] == 2'b00));
    chk(f4 == (e4[1:0] == 2'b00), {req, "/R4 flag w4"}, int'(f4), int'(e4[1:0] == 2'b00));
  endtask

  // drive a pulse on the selected lines; model applies step unless gated
  task automatic pulse(input bit u, input bit d, input string req);
    up = u; dn = d;
    ncyc(2);
    up = 1'b0; dn = 1'b0;
    ncyc(3);
    if (!gate && (u ^ d)) begin
      if (u) begin e16 += 16'd1; e4 += 4'd1; end
      else   begin e16 -= 16'd1; e4 -= 4'd1; end
    end
    check_all(req);
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    ncyc(3);
    check_all("R9 reset");
    rst_ni = 1'b1;
    ncyc(2);
    check_all("R4 reset flag");

    // R8 latency: rise before edge k, old after k+1, new after k+2
    up = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(cnt16 == 16'd0, "R8 no early step", int'(cnt16), 0);
    @(negedge clk);
    chk(cnt16 == 16'd1, "R8 step on third edge", int'(cnt16), 1);
    e16 = 16'd1; e4 = 4'd1;
    // R5: held high gives one step
    ncyc(10);
    check_all("R5 held line single step");
    up = 1'b0;
    ncyc(3);

    // R1/R7 sweep: narrow instance wraps past 15
    for (int i = 0; i < 20; i++) pulse(1'b1, 1'b0, "R1 R7 up sweep");
    // R2/R7 sweep down through zero
    for (int i = 0; i < 30; i++) pulse(1'b0, 1'b1, "R2 R7 down sweep");
    chk(cnt16 == 16'hFFF7, "R7 negative wrap", int'(cnt16), 'hFFF7);

    // R3: inhibit
    gate = 1'b1;
    ncyc(3);
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0, "R3 gated up");
    for (int i = 0; i < 2; i++) pulse(1'b0, 1'b1, "R3 gated down");
    gate = 1'b0;
    ncyc(3);
    pulse(1'b1, 1'b0, "R3 ungated up");

    // R6: simultaneous edges cancel
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b1, "R6 simultaneous");

    // R5: no activity
    ncyc(20);
    check_all("R5 idle hold");

    // R9: reset mid-run
    rst_ni = 1'b0;
    ncyc(2);
    e16 = '0; e4 = '0;
    check_all("R9 reset clears");
    rst_ni = 1'b1;
    ncyc(2);
    pulse(1'b0, 1'b1, "R2 R7 zero minus one");
    chk(cnt16 == 16'hFFFF, "R7 all ones", int'(cnt16), 'hFFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule